// File: doc/BRIEF.md
# Granule Tag Compare Engine

This block checks that every 16-byte granule touched by a memory access carries the same 4-bit tag as the pointer making the access. It accepts a 64-bit pointer and an access length minus one. From these it works out which granules the access spans. It then walks a byte-wide tag store through a synchronous read port with one cycle of read latency. Each byte of the store holds the tags of two neighbouring granules.

The scan runs in ascending granule order and stops at the first granule whose tag differs. When it stops, the block reports three things:
- whether the access passed;
- how many granules matched before the scan stopped;
- the address to blame for the fault.

When tag checking is disabled for a request, the block skips the store completely and reports a pass.

Requests arrive on a valid/ready interface. `req_ready` is high only while the engine is idle. While a scan is running, a request presented with `req_valid` is held off and stays pending until the engine returns to idle. Results are plain outputs qualified by a one-cycle `done` pulse, and they hold their values until the next request is accepted.

Top module: `tag_scan_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `done`, `mem_rd_en`, `res_pass`, `res_count` and `res_fault_addr` are all 0.
- R2: A request is taken only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 on every cycle where `busy` is 1.
- R3: Granule tags are packed into the store by granule address. The granule at address A lives in byte A>>5 (low MEM_AW bits of that index). Bits [3:0] of the byte hold the tag when A bit 4 is 0, and bits [7:4] hold it when A bit 4 is 1. The scan starts in the nibble selected by pointer bit 4. After a high nibble it moves to the low nibble of the next byte.
- R4: The tag expected for every granule is pointer bits [59:56].
- R5: The number of granules checked is ((pointer[3:0] + len_m1) >> 4) + 1. The access passes when all of them match, and on a pass `res_count` equals that number.
- R6: The scan stops at the first mismatching granule. On a fail, `res_count` is the zero-based index of that granule, and no byte beyond the one holding it is read.
- R7: On a fail at granule 0, `res_fault_addr` is the full original pointer. On a fail at granule n>0, it is (pointer with bits [3:0] cleared) + 16·n. On a pass it is the original pointer.
- R8: When `req_check_en` is 0, the request makes no memory reads. `done` rises on the cycle after acceptance with `res_pass`=1, `res_count`=0 and `res_fault_addr` equal to the pointer.
- R9: `res_pass`, `res_count` and `res_fault_addr` change only on a cycle where `done` is 1, and otherwise hold their values.
- R10: Each tag byte is read at most once per request, at ascending store addresses. Two reads are never issued on consecutive cycles.
- R11: `done` is a single-cycle pulse per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Access pointer, tag in bits [59:56] |
| req_len_m1 | input | LEN_W | Access size in bytes minus one |
| req_check_en | input | 1 | 1 = compare tags, 0 = bypass with pass |
| mem_rd_en | output | 1 | Tag store read strobe |
| mem_rd_addr | output | MEM_AW | Tag store byte index |
| mem_rd_data | input | 8 | Tag byte, valid one cycle after the strobe |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| res_pass | output | 1 | All granules matched |
| res_count | output | LEN_W-3 | Granules matched |
| res_fault_addr | output | ADDR_W | Blamed address |

## Verification
The bench builds the engine with MEM_AW=6 and LEN_W=8, which gives a 64-byte tag store covering 128 granules. With these values the widest span of 17 granules fits, including one that starts on an odd nibble. Before each vector, the bench places a wrong tag in the nibbles just outside the span and in the other nibble of the same byte. A scan that picks the wrong nibble, or runs one granule too far, therefore shows up as a result error or a read-count error. Failures are placed at granule 0, mid-span and on the last granule, which exercises both branches of the fault-address rule.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_TEST  = 2'd2
  } tsc_state_e;

  localparam int GRAN_LSB  = 4;
  localparam int BYTE_LSB  = 5;
  localparam int TAG_LSB   = 56;
  localparam int TAG_W     = 4;
endpackage

// File: rtl/tsc_span_calc.sv
module tsc_span_calc #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 8,
  parameter int MEM_AW = 10,
  localparam int CNT_W = LEN_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len_m1,
  output logic [ADDR_W-1:0] base_gran,
  output logic [CNT_W-1:0]  total,
  output logic              start_odd,
  output logic [MEM_AW-1:0] start_idx,
  output logic [3:0]        ptr_tag
);
  import tsc_pkg::*;

  logic [LEN_W:0] span_end;

  always_comb begin
    span_end  = {{(LEN_W-3){1'b0}}, addr[3:0]} + {1'b0, len_m1};
    total     = span_end[LEN_W:GRAN_LSB] + CNT_W'(1);
    base_gran = {addr[ADDR_W-1:GRAN_LSB], 4'b0000};
    start_odd = addr[GRAN_LSB];
    start_idx = addr[BYTE_LSB +: MEM_AW];
    ptr_tag   = addr[TAG_LSB +: TAG_W];
  end
endmodule

// File: rtl/tsc_byte_fetch.sv
module tsc_byte_fetch #(
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MEM_AW-1:0] load_idx,
  input  logic              issue,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic [7:0]        cur_byte
);
  logic [MEM_AW-1:0] ptr_q;
  logic              fresh_q;
  logic [7:0]        held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      fresh_q <= 1'b0;
      held_q  <= '0;
    end else begin
      if (load)       ptr_q <= load_idx;
      else if (issue) ptr_q <= ptr_q + MEM_AW'(1);
      fresh_q <= issue;
      if (fresh_q) held_q <= mem_rd_data;
    end
  end

  assign mem_rd_en   = issue;
  assign mem_rd_addr = ptr_q;
  assign cur_byte    = fresh_q ? mem_rd_data : held_q;
endmodule

// File: rtl/tsc_nibble_check.sv
module tsc_nibble_check (
  input  logic [7:0] byte_in,
  input  logic       odd,
  input  logic [3:0] tag,
  output logic       mismatch
);
  logic [1:0] nib_bad;

  for (genvar i = 0; i < 2; i++) begin : g_nib
    assign nib_bad[i] = |(byte_in[4*i +: 4] ^ tag);
  end

  assign mismatch = nib_bad[odd];
endmodule

// File: rtl/tag_scan_engine.sv
module tag_scan_engine #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 8,
  parameter int MEM_AW = 10,
  localparam int CNT_W = LEN_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len_m1,
  input  logic              req_check_en,
  output logic              mem_rd_en,
  output logic [MEM_AW-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              res_pass,
  output logic [CNT_W-1:0]  res_count,
  output logic [ADDR_W-1:0] res_fault_addr
);
  import tsc_pkg::*;

  tsc_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q, base_q;
  logic [CNT_W-1:0]  total_q, n_q;
  logic [3:0]        tag_q;
  logic              odd_q;

  logic [ADDR_W-1:0] s_base;
  logic [CNT_W-1:0]  s_total;
  logic              s_odd;
  logic [MEM_AW-1:0] s_idx;
  logic [3:0]        s_tag;
  logic [7:0]        cur_byte;
  logic              mismatch, accept, start_scan, last_gran;
  logic [ADDR_W-1:0] fail_addr;

  tsc_span_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_AW(MEM_AW)) span_i (
    .addr(req_addr), .len_m1(req_len_m1), .base_gran(s_base),
    .total(s_total), .start_odd(s_odd), .start_idx(s_idx), .ptr_tag(s_tag)
  );

  tsc_byte_fetch #(.MEM_AW(MEM_AW)) fetch_i (
    .clk(clk), .rst_n(rst_n), .load(start_scan), .load_idx(s_idx),
    .issue(state_q == ST_FETCH), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .cur_byte(cur_byte)
  );

  tsc_nibble_check cmp_i (
    .byte_in(cur_byte), .odd(odd_q), .tag(tag_q), .mismatch(mismatch)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign start_scan = accept && req_check_en;
  assign last_gran  = (n_q + CNT_W'(1)) == total_q;
  assign fail_addr  = (n_q == '0) ? ptr_q
                    : base_q + {{(ADDR_W-CNT_W-4){1'b0}}, n_q, 4'b0000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      ptr_q          <= '0;
      base_q         <= '0;
      total_q        <= '0;
      n_q            <= '0;
      tag_q          <= '0;
      odd_q          <= 1'b0;
      done           <= 1'b0;
      res_pass       <= 1'b0;
      res_count      <= '0;
      res_fault_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!req_check_en) begin
              done           <= 1'b1;
              res_pass       <= 1'b1;
              res_count      <= '0;
              res_fault_addr <= req_addr;
            end else begin
              ptr_q   <= req_addr;
              base_q  <= s_base;
              total_q <= s_total;
              tag_q   <= s_tag;
              odd_q   <= s_odd;
              n_q     <= '0;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: state_q <= ST_TEST;
        ST_TEST: begin
          if (mismatch) begin
            done           <= 1'b1;
            res_pass       <= 1'b0;
            res_count      <= n_q;
            res_fault_addr <= fail_addr;
            state_q        <= ST_IDLE;
          end else if (last_gran) begin
            done           <= 1'b1;
            res_pass       <= 1'b1;
            res_count      <= total_q;
            res_fault_addr <= ptr_q;
            state_q        <= ST_IDLE;
          end else begin
            n_q <= n_q + CNT_W'(1);
            if (odd_q) begin
              odd_q   <= 1'b0;
              state_q <= ST_FETCH;
            end else begin
              odd_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              res_pass,
  input logic [CNT_W-1:0]  res_count,
  input logic [ADDR_W-1:0] res_fault_addr
);
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(req_valid && req_ready)) |=> !done); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_pass) && $stable(res_count) && $stable(res_fault_addr))); // R9

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_en); // R8

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en); // R10
endmodule

bind tag_scan_engine tsc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .mem_rd_en(mem_rd_en), .res_pass(res_pass),
  .res_count(res_count), .res_fault_addr(res_fault_addr)
);

// File: tb/tag_scan_engine_tb.sv
module tag_scan_engine_tb_top;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 8;
  localparam int MEM_AW = 6;
  localparam int CNT_W  = LEN_W - 3;
  localparam int NGRAN  = 2 * (1 << MEM_AW);
  localparam int NVEC   = 10;

  // {pointer, len_m1, check_en, bad granule index (255 = none)}
  localparam logic [80:0] VEC [NVEC] = '{
    {64'h0300_0000_0000_0040, 8'd0,   1'b1, 8'd255},
    {64'h0500_0000_0000_0058, 8'd15,  1'b1, 8'd255},
    {64'h0A00_0000_0000_0100, 8'd63,  1'b1, 8'd255},
    {64'h0A00_0000_0000_0100, 8'd63,  1'b1, 8'd0},
    {64'h0C00_0000_0000_0137, 8'd40,  1'b1, 8'd2},
    {64'h0F00_0000_0000_0200, 8'd255, 1'b1, 8'd255},
    {64'h0F00_0000_0000_020F, 8'd255, 1'b1, 8'd9},
    {64'h0700_0000_0000_03F0, 8'd31,  1'b0, 8'd0},
    {64'h0100_0000_0000_0010, 8'd1,   1'b1, 8'd0},
    {64'h0E00_0000_0000_0060, 8'd31,  1'b1, 8'd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len_m1 = '0;
  logic              req_check_en = 1'b0;
  logic              mem_rd_en;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [7:0]        mem_rd_data = '0;
  logic              busy, done, res_pass;
  logic [CNT_W-1:0]  res_count;
  logic [ADDR_W-1:0] res_fault_addr;

  logic [7:0] tmem [1 << MEM_AW];
  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;

  always #4 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= tmem[mem_rd_addr];
  always @(negedge clk) if (mem_rd_en) rd_cnt <= rd_cnt + 1;

  tag_scan_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_AW(MEM_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len_m1(req_len_m1), .req_check_en(req_check_en),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .res_pass(res_pass), .res_count(res_count),
    .res_fault_addr(res_fault_addr)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_nib(input int g, input logic [3:0] v);
    int gg = ((g % NGRAN) + NGRAN) % NGRAN;
    if (gg[0]) tmem[gg >> 1][7:4] = v;
    else       tmem[gg >> 1][3:0] = v;
  endtask

  // Issue one request; returns the cycles from acceptance to done.
  task automatic issue(input logic [63:0] a, input logic [7:0] l,
                       input logic en, output int waited, output int reads);
    int base;
    @(negedge clk);
    req_addr = a; req_len_m1 = l; req_check_en = en; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    base = rd_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    reads = rd_cnt - base;
    check(done == 1'b1, "R11 done seen", 64'(done), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int waited, reads;
    for (int i = 0; i < (1 << MEM_AW); i++) tmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1 && busy == 1'b0 && done == 1'b0 && mem_rd_en == 1'b0,
          "R1 idle outputs", {60'd0, req_ready, busy, done, mem_rd_en}, 64'h8);
    check(res_pass == 1'b0 && res_count == '0 && res_fault_addr == '0,
          "R1 results", res_fault_addr, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      logic [63:0] a;
      logic [7:0]  l, bad;
      logic        en, exp_pass;
      logic [3:0]  ptag;
      int total, g0, odd, stop, exp_cnt, exp_rd;
      logic [63:0] exp_fault;
      {a, l, en, bad} = VEC[v];
      ptag  = a[59:56];
      g0    = int'(a[10:4]);
      odd   = int'(a[4]);
      total = ((int'(a[3:0]) + int'(l)) >> 4) + 1;
      // neighbours and other nibble get a wrong tag; span gets the right one
      set_nib(g0 - 1, ptag ^ 4'h5);
      set_nib(g0 + total, ptag ^ 4'h5);
      if (odd == 0 && total == 1) set_nib(g0 + 1, ptag ^ 4'h6);
      for (int g = 0; g < total; g++) set_nib(g0 + g, ptag);
      if (bad != 8'd255) set_nib(g0 + int'(bad), ptag ^ 4'h9);

      if (!en) begin
        exp_pass = 1'b1; exp_cnt = 0; exp_fault = a; exp_rd = 0;
      end else if (bad != 8'd255 && int'(bad) < total) begin
        exp_pass = 1'b0; exp_cnt = int'(bad);
        exp_fault = (bad == 0) ? a : {a[63:4], 4'h0} + 64'(16 * int'(bad));
        stop = int'(bad);
        exp_rd = ((odd + stop) >> 1) + 1;
      end else begin
        exp_pass = 1'b1; exp_cnt = total; exp_fault = a;
        exp_rd = ((odd + total - 1) >> 1) + 1;
      end

      issue(a, l, en, waited, reads);
      check(res_pass == exp_pass, $sformatf("R3 R4 R5 pass vec%0d", v),
            64'(res_pass), 64'(exp_pass));
      check(int'(res_count) == exp_cnt, $sformatf("R5 R6 count vec%0d", v),
            64'(res_count), 64'(exp_cnt));
      check(res_fault_addr == exp_fault, $sformatf("R7 fault vec%0d", v),
            res_fault_addr, exp_fault);
      check(reads == exp_rd, $sformatf("R6 R10 reads vec%0d", v),
            64'(reads), 64'(exp_rd));
      if (!en)
        check(waited == 0, "R8 bypass latency", 64'(waited), 64'd0);
    end

    // R11: done drops after one cycle; R9: results held while idle
    begin
      logic [63:0] f0;
      logic        p0;
      f0 = res_fault_addr; p0 = res_pass;
      @(negedge clk);
      check(done == 1'b0, "R11 done pulse width", 64'(done), 64'd0);
      repeat (5) @(negedge clk);
      check(res_fault_addr == f0 && res_pass == p0, "R9 results held",
            res_fault_addr, f0);
    end

    // R2: ready low while a long scan runs, request waits
    @(negedge clk);
    req_addr = VEC[5][80:17]; req_len_m1 = 8'd255; req_check_en = 1'b1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0 && busy == 1'b1, "R2 ready during scan",
          {62'd0, req_ready, busy}, 64'h1);
    while (!done) @(negedge clk);
    check(req_ready == 1'b1, "R2 ready after scan", 64'(req_ready), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule